// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block computes up to `NUM_OUT` Boolean functions of `NUM_IN` input variables in two-level AND-OR form. Each input is presented to an AND plane in true and complemented form. Each product term is the AND of the literals that its configuration row connects. Each output is the OR of the product terms that its own configuration row connects. The crosspoint map lives in registers, and the array path from inputs to outputs is purely combinational.

An elaboration parameter selects how much of the array can be configured. In the general variant both planes are configurable, and one product term may feed any number of outputs. In the decoder variant the AND plane is a fixed full minterm decoder, so each output row is a truth-table column. In the fixed-sum variant each output owns a contiguous group of product terms, and only the AND plane is configurable.

Rows are written one word at a time through a synchronous port that is gated by a load enable, while the array is not in use. After reset every crosspoint is connected. Writing a 0 bit removes a link, and writing a 1 bit keeps it.

Top module: `sop_array`

## Requirements
- R1: While reset is low, and after it is released until the first write, every AND-plane and OR-plane crosspoint reads as connected (all ones). In the decoder variant this drives every output to 1, and in the configurable-AND variants every output to 0.
- R2: The AND row for term t holds 2*NUM_IN bits. Bit 2i connects the true form of `in_vars[i]`, and bit 2i+1 connects its complement. A term is 1 exactly when every connected literal is 1.
- R3: A product term whose AND row is all zeros evaluates to 0 and never raises an output.
- R4: In the general variant, bit t of OR row j connects term t to `out_funcs[j]`, and a single term may be connected to several outputs at once.
- R5: In the decoder variant, term t is 1 exactly when `in_vars` equals t, and writes to AND-row addresses leave the outputs unchanged.
- R6: In the fixed-sum variant, `out_funcs[j]` is the OR of terms j*G to j*G+G-1, where G = NUM_TERMS/NUM_OUT, and writes to OR-row addresses leave the outputs unchanged.
- R7: A row is written only at a rising clock edge where both `cfg_load_en` and `cfg_wr` are 1. Any other write attempt is ignored.
- R8: Outputs reflect a written row from the clock edge that performs the write onward. They are valid within the same cycle, with no further delay.
- R9: Address t (0 ≤ t < NUM_TERMS) selects AND row t, and address NUM_TERMS+j selects OR row j. Each row takes the low bits of `cfg_wdata`. Addresses at or above NUM_TERMS+NUM_OUT are ignored.
- R10: Elaboration stops unless NUM_TERMS equals 2^NUM_IN in the decoder variant, and unless NUM_TERMS is a multiple of NUM_OUT in the fixed-sum variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset; restores the all-connected map |
| cfg_load_en | input | 1 | Load enable; writes are accepted only while it is high |
| cfg_wr | input | 1 | Write strobe for one configuration row |
| cfg_addr | input | AW | Row address (AND rows first, then OR rows) |
| cfg_wdata | input | WW | Row contents; bit 1 keeps a link, bit 0 removes it |
| in_vars | input | NUM_IN | Logic variables |
| out_funcs | output | NUM_OUT | Function outputs |

## Verification
The bench builds three instances with three inputs each.

- A decoder-variant instance with four outputs and eight terms. It realises the four minterm lists {1,2,4,7}, {0,3,5,6}, {1,3,5,7} and {2,3,4,5}, and is then reprogrammed so that one output gives the exclusive-or of two variables.
- A general-variant instance with four terms and two outputs. Here one term is shared between both outputs and one term is left empty, which exposes the rule that an empty term evaluates to 0.
- A fixed-sum instance with the same sizes. It brings the term grouping, and the ignored OR-row writes, within reach.

Small sizes keep exhaustive input sweeps cheap while still covering every address class, including unused addresses.

// File: rtl/sop_pkg.sv
`timescale 1ns/1ps
package sop_pkg;
   typedef enum logic [1:0] {
      SOP_FULL     = 2'd0,
      SOP_DECODER  = 2'd1,
      SOP_FIXED_OR = 2'd2
   } sop_mode_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/sop_cfg_store.sv
`timescale 1ns/1ps
module sop_cfg_store #(
   parameter int unsigned         NUM_IN    = 4,
   parameter int unsigned         NUM_TERMS = 16,
   parameter int unsigned         NUM_OUT   = 4,
   parameter sop_pkg::sop_mode_e  MODE      = sop_pkg::SOP_FULL,
   parameter int unsigned         AW        = 5,
   parameter int unsigned         WW        = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           load_en,
   input  logic                           wr,
   input  logic [AW-1:0]                  addr,
   input  logic [WW-1:0]                  wdata,
   output logic [NUM_TERMS*2*NUM_IN-1:0]  and_cfg,
   output logic [NUM_OUT*NUM_TERMS-1:0]   or_cfg
);
   localparam int unsigned LW = 2 * NUM_IN;

   logic wr_en;
   logic unused_wdata;
   assign wr_en        = load_en & wr;
   assign unused_wdata = ^wdata;

   generate
      if (MODE != sop_pkg::SOP_DECODER) begin : g_and_rows
         for (genvar t = 0; t < NUM_TERMS; t++) begin : g_row
            logic [LW-1:0] row_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  row_q <= '1;
               else if (wr_en && addr == AW'(t))
                  row_q <= wdata[LW-1:0];
            end
            assign and_cfg[t*LW +: LW] = row_q;
         end
      end else begin : g_and_fixed
         assign and_cfg = '1;
      end

      if (MODE != sop_pkg::SOP_FIXED_OR) begin : g_or_rows
         for (genvar j = 0; j < NUM_OUT; j++) begin : g_row
            logic [NUM_TERMS-1:0] row_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  row_q <= '1;
               else if (wr_en && addr == AW'(NUM_TERMS + j))
                  row_q <= wdata[NUM_TERMS-1:0];
            end
            assign or_cfg[j*NUM_TERMS +: NUM_TERMS] = row_q;
         end
      end else begin : g_or_fixed
         assign or_cfg = '1;
      end
   endgenerate
endmodule

// File: rtl/sop_and_plane.sv
`timescale 1ns/1ps
module sop_and_plane #(
   parameter int unsigned        NUM_IN    = 4,
   parameter int unsigned        NUM_TERMS = 16,
   parameter sop_pkg::sop_mode_e MODE      = sop_pkg::SOP_FULL
) (
   input  logic [NUM_IN-1:0]              in_vars,
   input  logic [NUM_TERMS*2*NUM_IN-1:0]  and_cfg,
   output logic [NUM_TERMS-1:0]           terms
);
   localparam int unsigned LW = 2 * NUM_IN;

   generate
      if (MODE == sop_pkg::SOP_DECODER) begin : g_decode
         logic unused_cfg;
         assign unused_cfg = ^and_cfg;
         for (genvar t = 0; t < NUM_TERMS; t++) begin : g_min
            assign terms[t] = (in_vars == NUM_IN'(t));
         end
      end else begin : g_prog
         logic [LW-1:0] lits;
         for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
            assign lits[2*i]   =  in_vars[i];
            assign lits[2*i+1] = ~in_vars[i];
         end
         for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
            logic [LW-1:0] row;
            assign row      = and_cfg[t*LW +: LW];
            // an empty row must give 0, not the AND identity
            assign terms[t] = (|row) & (&(lits | ~row));
         end
      end
   endgenerate
endmodule

// File: rtl/sop_or_plane.sv
`timescale 1ns/1ps
module sop_or_plane #(
   parameter int unsigned        NUM_TERMS = 16,
   parameter int unsigned        NUM_OUT   = 4,
   parameter sop_pkg::sop_mode_e MODE      = sop_pkg::SOP_FULL
) (
   input  logic [NUM_TERMS-1:0]          terms,
   input  logic [NUM_OUT*NUM_TERMS-1:0]  or_cfg,
   output logic [NUM_OUT-1:0]            out_funcs
);
   localparam int unsigned GROUP = NUM_TERMS / NUM_OUT;

   generate
      if (MODE == sop_pkg::SOP_FIXED_OR) begin : g_fixed
         logic unused_cfg;
         assign unused_cfg = ^or_cfg;
         for (genvar j = 0; j < NUM_OUT; j++) begin : g_sum
            assign out_funcs[j] = |terms[j*GROUP +: GROUP];
         end
      end else begin : g_prog
         for (genvar j = 0; j < NUM_OUT; j++) begin : g_sum
            assign out_funcs[j] = |(terms & or_cfg[j*NUM_TERMS +: NUM_TERMS]);
         end
      end
   endgenerate
endmodule

// File: rtl/sop_array.sv
`timescale 1ns/1ps
module sop_array #(
   parameter int unsigned        NUM_IN    = 4,
   parameter int unsigned        NUM_TERMS = 16,
   parameter int unsigned        NUM_OUT   = 4,
   parameter sop_pkg::sop_mode_e MODE      = sop_pkg::SOP_FULL,
   localparam int unsigned       LW        = 2 * NUM_IN,
   localparam int unsigned       WW        = sop_pkg::max_u(LW, NUM_TERMS),
   localparam int unsigned       AW        = $clog2(NUM_TERMS + NUM_OUT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_load_en,
   input  logic               cfg_wr,
   input  logic [AW-1:0]      cfg_addr,
   input  logic [WW-1:0]      cfg_wdata,
   input  logic [NUM_IN-1:0]  in_vars,
   output logic [NUM_OUT-1:0] out_funcs
);
   // R10: parameter sanity at elaboration
   generate
      if (NUM_IN < 1 || NUM_TERMS < 1 || NUM_OUT < 1) begin : g_bad_size
         $error("sop_array: sizes must be non-zero");
      end
      if (MODE == sop_pkg::SOP_DECODER && NUM_TERMS != (1 << NUM_IN)) begin : g_bad_dec
         $error("sop_array: decoder variant needs NUM_TERMS == 2**NUM_IN");
      end
      if (MODE == sop_pkg::SOP_FIXED_OR && (NUM_TERMS % NUM_OUT) != 0) begin : g_bad_grp
         $error("sop_array: fixed-sum variant needs NUM_TERMS divisible by NUM_OUT");
      end
   endgenerate

   logic [NUM_TERMS*LW-1:0]      and_cfg;
   logic [NUM_OUT*NUM_TERMS-1:0] or_cfg;
   logic [NUM_TERMS-1:0]         terms;

   sop_cfg_store #(
      .NUM_IN(NUM_IN), .NUM_TERMS(NUM_TERMS), .NUM_OUT(NUM_OUT),
      .MODE(MODE), .AW(AW), .WW(WW)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .load_en(cfg_load_en), .wr(cfg_wr),
      .addr(cfg_addr), .wdata(cfg_wdata),
      .and_cfg(and_cfg), .or_cfg(or_cfg)
   );

   sop_and_plane #(
      .NUM_IN(NUM_IN), .NUM_TERMS(NUM_TERMS), .MODE(MODE)
   ) u_and (
      .in_vars(in_vars), .and_cfg(and_cfg), .terms(terms)
   );

   sop_or_plane #(
      .NUM_TERMS(NUM_TERMS), .NUM_OUT(NUM_OUT), .MODE(MODE)
   ) u_or (
      .terms(terms), .or_cfg(or_cfg), .out_funcs(out_funcs)
   );
endmodule

// File: rtl/sop_array_chk.sv
`timescale 1ns/1ps
module sop_array_chk #(
   parameter int unsigned        NUM_IN    = 4,
   parameter int unsigned        NUM_TERMS = 16,
   parameter int unsigned        NUM_OUT   = 4,
   parameter sop_pkg::sop_mode_e MODE      = sop_pkg::SOP_FULL,
   parameter int unsigned        AW        = 5
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           load_en,
   input logic                           wr,
   input logic [AW-1:0]                  addr,
   input logic [NUM_TERMS*2*NUM_IN-1:0]  and_cfg,
   input logic [NUM_OUT*NUM_TERMS-1:0]   or_cfg,
   input logic [NUM_TERMS-1:0]           terms,
   input logic [NUM_OUT-1:0]             out_funcs
);
   localparam int unsigned LW    = 2 * NUM_IN;
   localparam int unsigned GROUP = NUM_TERMS / NUM_OUT;
   localparam int unsigned LAST  = NUM_TERMS + NUM_OUT;

   a_r1_reset_map: assert property (@(posedge clk)
      !rst_n |=> (&and_cfg) && (&or_cfg));

   a_r7_no_write_when_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_en && wr) |=> $stable(and_cfg) && $stable(or_cfg));

   a_r9_unmapped_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && wr && 32'(addr) >= LAST) |=> $stable(and_cfg) && $stable(or_cfg));

   a_r4_no_term_no_output: assert property (@(posedge clk) disable iff (!rst_n)
      (terms == '0) |-> (out_funcs == '0));

   generate
      if (MODE == sop_pkg::SOP_DECODER) begin : g_dec
         a_r5_one_minterm: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(terms) == 1);
      end else begin : g_prog_and
         for (genvar t = 0; t < NUM_TERMS; t++) begin : g_t
            a_r3_empty_term_low: assert property (@(posedge clk) disable iff (!rst_n)
               (and_cfg[t*LW +: LW] == '0) |-> !terms[t]);
         end
      end
      if (MODE == sop_pkg::SOP_FIXED_OR) begin : g_fix
         for (genvar j = 0; j < NUM_OUT; j++) begin : g_j
            a_r6_group_drives_output: assert property (@(posedge clk) disable iff (!rst_n)
               out_funcs[j] |-> (|terms[j*GROUP +: GROUP]));
         end
      end
   endgenerate
endmodule

bind sop_array sop_array_chk #(
   .NUM_IN(NUM_IN), .NUM_TERMS(NUM_TERMS), .NUM_OUT(NUM_OUT), .MODE(MODE), .AW(AW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .load_en(cfg_load_en), .wr(cfg_wr), .addr(cfg_addr),
   .and_cfg(and_cfg), .or_cfg(or_cfg), .terms(terms), .out_funcs(out_funcs)
);

// File: tb/sop_array_test.sv
`timescale 1ns/1ps
module sop_array_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_en = 1'b0;
   logic       wr_dec = 1'b0, wr_full = 1'b0, wr_fix = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [2:0] in_vars = '0;
   logic [3:0] out_dec;
   logic [1:0] out_full, out_fix;
   int         n_chk = 0, n_fail = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   // decoder variant: 3 inputs, 8 minterms, 4 outputs; OR rows at 8..11
   sop_array #(.NUM_IN(3), .NUM_TERMS(8), .NUM_OUT(4), .MODE(sop_pkg::SOP_DECODER)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_load_en(load_en), .cfg_wr(wr_dec),
      .cfg_addr(addr), .cfg_wdata(wdata), .in_vars(in_vars), .out_funcs(out_dec));

   // general variant: 4 terms (rows 0..3), 2 outputs (rows 4..5)
   sop_array #(.NUM_IN(3), .NUM_TERMS(4), .NUM_OUT(2), .MODE(sop_pkg::SOP_FULL)) uut_full (
      .clk(clk), .rst_n(rst_n), .cfg_load_en(load_en), .cfg_wr(wr_full),
      .cfg_addr(addr[2:0]), .cfg_wdata(wdata[5:0]), .in_vars(in_vars), .out_funcs(out_full));

   // fixed-sum variant: out0 = t0|t1, out1 = t2|t3
   sop_array #(.NUM_IN(3), .NUM_TERMS(4), .NUM_OUT(2), .MODE(sop_pkg::SOP_FIXED_OR)) uut_fix (
      .clk(clk), .rst_n(rst_n), .cfg_load_en(load_en), .cfg_wr(wr_fix),
      .cfg_addr(addr[2:0]), .cfg_wdata(wdata[5:0]), .in_vars(in_vars), .out_funcs(out_fix));

   // input, expected {F4,F3,F2,F1}
   localparam logic [6:0] DEC_TAB [8] = '{
      {3'd0, 4'b0010}, {3'd1, 4'b0101}, {3'd2, 4'b1001}, {3'd3, 4'b1110},
      {3'd4, 4'b1001}, {3'd5, 4'b1110}, {3'd6, 4'b0010}, {3'd7, 4'b0101}};

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   // which: 0 decoder, 1 general, 2 fixed-sum
   task automatic cfg_write(input int which, input logic [3:0] a, input logic [7:0] d,
                            input logic le);
      @(negedge clk);
      addr = a; wdata = d; load_en = le;
      wr_dec = (which == 0); wr_full = (which == 1); wr_fix = (which == 2);
      @(negedge clk);
      wr_dec = 1'b0; wr_full = 1'b0; wr_fix = 1'b0; load_en = 1'b0;
   endtask

   task automatic apply(input logic [2:0] v);
      in_vars = v;
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      apply(3'd5);
      check("R1 decoder all connected", {4'b0, out_dec}, 8'h0F);
      check("R1 general all connected", {6'b0, out_full}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      apply(3'd2);
      check("R1 fixed after release", {6'b0, out_fix}, 8'h00);

      // R8: first OR row visible right after its write edge
      cfg_write(0, 4'd8, 8'h96, 1'b1);
      apply(3'd0);
      check("R8 row visible next cycle", {4'b0, out_dec}, 8'h0E);
      cfg_write(0, 4'd9, 8'h69, 1'b1);
      cfg_write(0, 4'd10, 8'hAA, 1'b1);
      cfg_write(0, 4'd11, 8'h3C, 1'b1);

      // R5 / R9: minterm lists through the table
      for (int k = 0; k < 8; k++) begin
         apply(DEC_TAB[k][6:4]);
         check("R5 minterm functions", {4'b0, out_dec}, {4'b0, DEC_TAB[k][3:0]});
      end

      // R5: AND-row write ignored in decoder variant
      cfg_write(0, 4'd3, 8'h00, 1'b1);
      apply(3'd3);
      check("R5 AND write ignored", {4'b0, out_dec}, 8'h0E);
      // R9: unmapped address ignored
      cfg_write(0, 4'd15, 8'h00, 1'b1);
      apply(3'd5);
      check("R9 unmapped addr ignored", {4'b0, out_dec}, 8'h0E);
      // R7: write with load enable low ignored
      cfg_write(0, 4'd8, 8'h00, 1'b0);
      apply(3'd4);
      check("R7 gated write ignored", {4'b0, out_dec}, 8'h09);

      // R5: XOR of in[1], in[0] through minterms {1,2,5,6}
      cfg_write(0, 4'd8, 8'h66, 1'b1);
      for (int v = 0; v < 8; v++) begin
         apply(3'(v));
         check("R5 decoder xor", {7'b0, out_dec[0]}, {7'b0, in_vars[1] ^ in_vars[0]});
      end

      // general variant: bit 2i true, bit 2i+1 complement (R2)
      cfg_write(1, 4'd0, 8'h09, 1'b1);   // A'B  (A=in1, B=in0)
      cfg_write(1, 4'd1, 8'h06, 1'b1);   // AB'
      cfg_write(1, 4'd2, 8'h10, 1'b1);   // in2
      cfg_write(1, 4'd3, 8'h00, 1'b1);   // empty
      cfg_write(1, 4'd4, 8'h03, 1'b1);   // out0 = t0|t1
      cfg_write(1, 4'd5, 8'h0E, 1'b1);   // out1 = t1|t2|t3 (t1 shared)
      apply(3'd0);
      check("R3 empty term stays low", {6'b0, out_full}, 8'h00);
      for (int v = 0; v < 8; v++) begin
         logic a, b, c;
         apply(3'(v));
         a = in_vars[1]; b = in_vars[0]; c = in_vars[2];
         check("R2 R4 shared terms", {6'b0, out_full},
               {6'b0, (a & ~b) | c, a ^ b});
      end
      cfg_write(1, 4'd4, 8'h00, 1'b0);
      apply(3'd1);
      check("R7 gated write general", {6'b0, out_full}, 8'h01);

      // R6: fixed-sum grouping
      cfg_write(2, 4'd0, 8'h05, 1'b1);   // in0 & in1
      cfg_write(2, 4'd1, 8'h20, 1'b1);   // ~in2
      cfg_write(2, 4'd2, 8'h00, 1'b1);   // empty
      cfg_write(2, 4'd3, 8'h12, 1'b1);   // in2 & ~in0
      cfg_write(2, 4'd4, 8'h00, 1'b1);   // OR-row write, ignored
      for (int v = 0; v < 8; v++) begin
         apply(3'(v));
         check("R6 fixed groups", {6'b0, out_fix},
               {6'b0, in_vars[2] & ~in_vars[0],
                (in_vars[0] & in_vars[1]) | ~in_vars[2]});
      end

      // R1: reset restores the all-connected map
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      apply(3'd6);
      check("R1 reset restores map", {4'b0, out_dec}, 8'h0F);
      rst_n = 1'b1;

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule